// File: doc/BRIEF.md
# Rotated Immediate Constant Encoder

This block decides whether a 32-bit constant can be loaded by one data-move instruction. Such an instruction carries an 8-bit payload and a 4-bit rotation code. The constant it produces is the payload rotated right by twice the code. When the constant does not fit that form, the block tries the bitwise complement of the constant, which a move-inverted opcode can load. When neither form fits, the block reports that the constant must come from a literal load or from a sequence of several instructions.

An instruction-generation stage presents one constant with a valid strobe. One clock later it receives a single-cycle result strobe with the verdict. The verdict is made of an encodable flag, an invert-select flag, the payload and the rotation code. The search covers only even rotation amounts. Every rotation is tried in parallel, and the smallest working code is kept.

Top module: `rotimm_encoder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high at a rising clock edge, and low otherwise.
- R2: While `rst` is high at a rising edge, `out_valid`, `out_fits`, `out_invert`, `out_payload` and `out_rot` all become 0.
- R3: When `in_value` equals some 8-bit value P rotated right by 2*r bits (r in 0..15), the result has `out_fits`=1 and `out_invert`=0. Rotating `out_payload` right by 2*`out_rot` then reproduces `in_value`.
- R4: When several rotation codes produce the constant, `out_rot` is the smallest such code.
- R5: Any `in_value` from 0 to 255 gives `out_fits`=1, `out_invert`=0, `out_rot`=0 and `out_payload` equal to `in_value`.
- R6: When `in_value` is not directly encodable but its bitwise complement is, the result has `out_fits`=1 and `out_invert`=1. The bitwise inverse of `out_payload` rotated right by 2*`out_rot` then equals `in_value`, and the smallest code is used.
- R7: An input of 0xFFFFFFFF gives `out_fits`=1, `out_invert`=1, `out_payload`=0 and `out_rot`=0.
- R8: When neither the constant nor its complement is encodable, the result has `out_fits`=0, `out_invert`=0, `out_payload`=0 and `out_rot`=0. A low `out_fits` means a literal load or a multi-instruction build is needed.
- R9: In a cycle that follows one without `in_valid`, all result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Constant on `in_value` is presented this cycle |
| in_value | input | 32 | Constant to encode |
| out_valid | output | 1 | Single-cycle strobe, one clock after `in_valid` |
| out_fits | output | 1 | Constant loadable by one move or move-inverted |
| out_invert | output | 1 | Move-inverted form selected |
| out_payload | output | 8 | 8-bit payload of the chosen form |
| out_rot | output | 4 | Rotation code r, meaning rotate right by 2*r |

## Verification
The output assertions compare each result with the constant presented one cycle earlier. They therefore assume that `in_value` is sampled only on the edge where `in_valid` is high, and that `in_valid` is low during the final reset cycle. The bench drives each constant for a single cycle between falling edges and drops `in_valid` before releasing reset. The sweep covers every payload at every even rotation, the complement of each of those, all small constants and a block of random words. In each case the expected verdict is computed by rotating one bit at a time in the bench.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
    parameter int WORD_W = 32;
    parameter int PAY_W  = 8;
    parameter int NROT   = WORD_W / 2;
    parameter int ROT_W  = $clog2(NROT);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAY_W-1:0]  pay_t;
    typedef logic [ROT_W-1:0]  rot_t;

    // outcome of one rotation search over a single word
    typedef struct packed {
        logic hit;
        pay_t payload;
        rot_t rot;
    } match_t;

    // final verdict presented at the block edge
    typedef struct packed {
        logic fits;
        logic invert;
        pay_t payload;
        rot_t rot;
    } enc_t;

    // rotate right by an even amount given as a code
    function automatic word_t expand_code(pay_t p, rot_t r);
        word_t w;
        int unsigned sh;
        w  = word_t'(p);
        sh = 2 * int'(r);
        if (sh == 0) return w;
        return (w >> sh) | (w << (WORD_W - sh));
    endfunction
endpackage

// File: rtl/rotimm_search.sv
module rotimm_search
    import rotimm_pkg::*;
(
    input  word_t  value,
    output match_t found
);
    pay_t pay_by_rot [NROT];
    logic [NROT-1:0] hit_by_rot;

    // one lane per even rotation: undo the rotation, test the upper bits
    for (genvar g = 0; g < NROT; g++) begin : g_lane
        localparam int SH = 2 * g;
        word_t undone;
        if (SH == 0) begin : g_zero
            assign undone = value;
        end else begin : g_rot
            assign undone = {value[WORD_W-1-SH:0], value[WORD_W-1:WORD_W-SH]};
        end
        assign hit_by_rot[g] = ~|undone[WORD_W-1:PAY_W];
        assign pay_by_rot[g] = undone[PAY_W-1:0];
    end

    // smallest code wins: scan from the top so low codes overwrite
    always_comb begin
        found = '0;
        for (int g = NROT - 1; g >= 0; g--) begin
            if (hit_by_rot[g]) begin
                found.hit     = 1'b1;
                found.payload = pay_by_rot[g];
                found.rot     = rot_t'(g);
            end
        end
    end
endmodule

// File: rtl/rotimm_select.sv
module rotimm_select
    import rotimm_pkg::*;
(
    input  match_t direct,
    input  match_t inverse,
    output enc_t   verdict
);
    always_comb begin
        verdict = '0;
        if (direct.hit) begin
            verdict.fits    = 1'b1;
            verdict.payload = direct.payload;
            verdict.rot     = direct.rot;
        end else if (inverse.hit) begin
            verdict.fits    = 1'b1;
            verdict.invert  = 1'b1;
            verdict.payload = inverse.payload;
            verdict.rot     = inverse.rot;
        end
    end
endmodule

// File: rtl/rotimm_encoder.sv
module rotimm_encoder
    import rotimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_value,
    output logic              out_valid,
    output logic              out_fits,
    output logic              out_invert,
    output logic [PAY_W-1:0]  out_payload,
    output logic [ROT_W-1:0]  out_rot
);
    match_t m_direct, m_inverse;
    enc_t   verdict_d, verdict_q;
    logic   valid_q;

    rotimm_search u_direct  (.value(in_value),  .found(m_direct));
    rotimm_search u_inverse (.value(~in_value), .found(m_inverse));
    rotimm_select u_select  (.direct(m_direct), .inverse(m_inverse), .verdict(verdict_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) verdict_q <= verdict_d;
        end
    end

    assign out_valid   = valid_q;
    assign out_fits    = verdict_q.fits;
    assign out_invert  = verdict_q.invert;
    assign out_payload = verdict_q.payload;
    assign out_rot     = verdict_q.rot;

    // R1
    strobe_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R3
    direct_roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fits && !out_invert) |->
            (expand_code(out_payload, out_rot) == $past(in_value)));

    // R6
    inverted_roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_invert) |->
            (out_fits && (~expand_code(out_payload, out_rot) == $past(in_value))));

    // R5
    small_constant_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(in_value) < 32'd256)) |->
            (out_fits && !out_invert && out_rot == '0 &&
             word_t'(out_payload) == $past(in_value)));

    // R8
    pool_fields_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !out_fits |-> (!out_invert && out_payload == '0 && out_rot == '0));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |->
            ($stable(out_fits) && $stable(out_invert) &&
             $stable(out_payload) && $stable(out_rot)));
endmodule

// File: tb/rotimm_encoder_bench.sv
module rotimm_encoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic        out_valid, out_fits, out_invert;
    logic [7:0]  out_payload;
    logic [3:0]  out_rot;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    rotimm_encoder u_rotimm_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
        .out_valid(out_valid), .out_fits(out_fits), .out_invert(out_invert),
        .out_payload(out_payload), .out_rot(out_rot)
    );

    // rotate left one bit at a time
    function automatic logic [31:0] rotl_bits(logic [31:0] x, int n);
        logic [31:0] y = x;
        for (int i = 0; i < n; i++) y = {y[30:0], y[31]};
        return y;
    endfunction

    function automatic logic [31:0] rotr_bits(logic [31:0] x, int n);
        logic [31:0] y = x;
        for (int i = 0; i < n; i++) y = {y[0], y[31:1]};
        return y;
    endfunction

    // expected {fits, invert, payload, rot}
    function automatic logic [13:0] expect_of(logic [31:0] v);
        for (int r = 0; r < 16; r++)
            if (rotl_bits(v, 2 * r) < 32'd256)
                return {1'b1, 1'b0, rotl_bits(v, 2 * r)[7:0], 4'(r)};
        for (int r = 0; r < 16; r++)
            if (rotl_bits(~v, 2 * r) < 32'd256)
                return {1'b1, 1'b1, rotl_bits(~v, 2 * r)[7:0], 4'(r)};
        return '0;
    endfunction

    task automatic check(string tag, logic [31:0] v, logic [13:0] got, logic [13:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s in=%08h actual=%04h expected=%04h", tag, v, got, exp);
        end
    endtask

    task automatic apply(logic [31:0] v, string tag);
        logic [13:0] exp, got;
        logic [31:0] back;
        @(negedge clk);
        in_valid = 1'b1;
        in_value = v;
        @(negedge clk);
        in_valid = 1'b0;
        in_value = $urandom;
        exp = expect_of(v);
        got = {out_fits, out_invert, out_payload, out_rot};
        check("R1 strobe", v, {13'd0, out_valid}, 14'd1);
        check(tag, v, got, exp);
        if (out_fits) begin
            back = rotr_bits({24'd0, out_payload}, 2 * int'(out_rot));
            if (out_invert) back = ~back;
            check(out_invert ? "R6 roundtrip" : "R3 roundtrip", v,
                  {13'd0, back == v}, 14'd1);
        end
    endtask

    initial begin
        logic [13:0] held;
        repeat (3) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_value = 32'h5;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 reset", 32'h5, {out_valid, out_fits, out_invert, out_payload, out_rot},
              15'd0 >> 1);
        @(negedge clk);
        rst = 1'b0;

        // R5 small constants
        for (int v = 0; v < 256; v++) apply(32'(v), "R5 small");

        // R7 all ones
        apply(32'hFFFF_FFFF, "R7 all-ones");
        check("R7 all-ones fields", 32'hFFFF_FFFF,
              {out_fits, out_invert, out_payload, out_rot}, {1'b1, 1'b1, 8'd0, 4'd0});

        // R3 R4: every payload at every even rotation, then R6 on the complements
        for (int p = 0; p < 256; p++)
            for (int r = 0; r < 16; r++)
                apply(rotr_bits(32'(p), 2 * r), "R3 R4 direct");
        for (int p = 0; p < 256; p++)
            for (int r = 0; r < 16; r++)
                apply(~rotr_bits(32'(p), 2 * r), "R6 inverted");

        // R8 and boundaries
        apply(32'h0000_01FE, "R8 odd-rotation");
        apply(32'h0000_0101, "R8 wide");
        apply(32'h1234_5678, "R8 random-like");
        check("R8 pool fields", 32'h1234_5678,
              {out_fits, out_invert, out_payload, out_rot}, 14'd0);
        apply(32'h0000_03FC, "R3 R4 top-code");
        apply(32'hF000_000F, "R3 R4 wrap");
        apply(32'h7FFF_FFFF, "R6 msb-clear");
        apply(32'hFFFF_FF00, "R6 low-byte");
        apply(32'h0000_0100, "R3 R4 ninth-bit");

        // R9 hold, R1 single-cycle strobe
        apply(32'hFF00_0000, "R3 R4 top-byte");
        held = {out_fits, out_invert, out_payload, out_rot};
        repeat (3) @(negedge clk);
        check("R1 strobe low", 32'hFF00_0000, {13'd0, out_valid}, 14'd0);
        check("R9 hold", 32'hFF00_0000, {out_fits, out_invert, out_payload, out_rot}, held);

        // random words
        for (int i = 0; i < 2000; i++) apply($urandom, "R3 R6 R8 random");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                vectors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule